// File: doc/BRIEF.md
# Dual-Port Shared Memory with Mailbox Interrupts

This block is a synchronous, two-port 8K x 16 shared memory for two processors that need to exchange data. Each side has its own enable, write select, output enable, two byte-lane selects, address, write data and read data. Either side may read or write any word in any cycle, independently of the other. Read data is registered and appears on the port's output one clock after the request. When the request is not a read, the output is zero.

Both ports can name the same word in the same cycle. In master mode the block settles this itself: the left side always wins, the right side's write is dropped, and the right side's busy output reports the conflict. In slave mode the busy outputs stay low. Each side's write is then gated by an external busy input, which lets several copies be stacked side by side for a wider word with one master making the decision.

The two highest words double as mailboxes. A write there by one side raises the other side's interrupt, and a read by the receiving side lowers it.

Top module: `dpm_dual_ram`

## Requirements
- R1: Each port can write any address and read any address independently of the other port. The data of a read appears on that port's data-out on the clock edge after the request.
- R2: A port's data-out is zero in the cycle after it makes no read, that is, when enable is low, output enable is low, or write is selected. A port with enable low changes no state.
- R3: The byte select `hi` covers data bits 15..8 and the byte select `lo` covers bits 7..0. An unselected lane is not written, and it reads back as zero.
- R4: In master mode (`master`=1), when both ports are enabled at the same address, the right port's busy output is 1 in the following cycle. The left port's busy output is never 1.
- R5: In master mode, a right-port write to the address the left port is accessing in the same cycle is suppressed. The left port's write takes effect.
- R6: When one port writes a word that the other port reads in the same cycle, the reader gets the old value. A read of that word in the next cycle returns the new value.
- R7: In slave mode (`master`=0), both busy outputs are 0. A port whose busy input is 1 has its write suppressed. When neither port is blocked and both write the same word, the left port's data is kept.
- R8: An effective left-port write (at least one lane) to 0x1FFF sets the right interrupt to 1 in the next cycle. A right-port read of 0x1FFF clears it.
- R9: An effective right-port write to 0x1FFE sets the left interrupt to 1 in the next cycle. A left-port read of 0x1FFE clears it.
- R10: A mailbox read by the sending port leaves the interrupt unchanged. When a set and a clear of one interrupt occur in the same cycle, the set wins.
- R11: While reset is high, both data-outs, both busy outputs and both interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master | input | 1 | 1: busy generated internally; 0: busy taken from inputs |
| a_en | input | 1 | Left port enable |
| a_wr | input | 1 | Left port write select (1 write, 0 read) |
| a_oe | input | 1 | Left port output enable |
| a_hi | input | 1 | Left port upper byte select |
| a_lo | input | 1 | Left port lower byte select |
| a_addr | input | 13 | Left port word address |
| a_din | input | 16 | Left port write data |
| a_busy_i | input | 1 | Left port external busy (slave mode) |
| a_dout | output | 16 | Left port read data |
| a_busy_o | output | 1 | Left port busy flag |
| a_irq | output | 1 | Left port mailbox interrupt |
| b_en | input | 1 | Right port enable |
| b_wr | input | 1 | Right port write select (1 write, 0 read) |
| b_oe | input | 1 | Right port output enable |
| b_hi | input | 1 | Right port upper byte select |
| b_lo | input | 1 | Right port lower byte select |
| b_addr | input | 13 | Right port word address |
| b_din | input | 16 | Right port write data |
| b_busy_i | input | 1 | Right port external busy (slave mode) |
| b_dout | output | 16 | Right port read data |
| b_busy_o | output | 1 | Right port busy flag |
| b_irq | output | 1 | Right port mailbox interrupt |

## Verification
The bench drives both ports at the same word in write/write and write/read pairs. If the priority were reversed, the right port's data would survive and the busy flag would land on the wrong side. If the read-before-write order were wrong, the reader would see new data one cycle early.

It sets and clears each mailbox in the same cycle, and reads each mailbox from the wrong side. A design that let the clear win would lose a message, and one that decoded the wrong address would clear another port's interrupt.

Single-lane writes followed by opposite-lane reads show whether a lane leaks. Slave-mode runs with busy inputs toggling catch a design that ignores the external block or still drives its own busy flags.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Decoded request of one port for one cycle.
  typedef struct packed {
    logic       rd;     // read with output enabled
    logic       wr;     // write requested (before arbitration)
    logic [1:0] lanes;  // {upper, lower} byte lanes
  } port_op_t;

  function automatic port_op_t decode_op(input logic en, input logic wr,
                                         input logic oe, input logic hi,
                                         input logic lo);
    port_op_t o;
    o.rd    = en & oe & ~wr;
    o.wr    = en & wr;
    o.lanes = {hi, lo};
    return o;
  endfunction

endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          a_en,
  input  logic          b_en,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic          a_busy_i,
  input  logic          b_busy_i,
  output logic          a_block,
  output logic          b_block,
  output logic          a_busy_o,
  output logic          b_busy_o
);

  logic clash;

  // Left side has fixed priority: only the right side can lose.
  assign clash   = a_en & b_en & (a_addr == b_addr);
  assign a_block = master ? 1'b0  : a_busy_i;
  assign b_block = master ? clash : b_busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_busy_o <= 1'b0;
      b_busy_o <= 1'b0;
    end else begin
      a_busy_o <= 1'b0;
      b_busy_o <= master & clash;
    end
  end

  a_r4_right_flagged: assert property (@(posedge clk) disable iff (rst)
    (master && a_en && b_en && a_addr == b_addr) |=> b_busy_o);

  a_r4_left_never: assert property (@(posedge clk) disable iff (rst)
    master |=> !a_busy_o);

  a_r7_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    !master |=> (!a_busy_o && !b_busy_o));

endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
  parameter int AW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  input  logic [1:0]    a_wlanes,
  input  logic          a_rd,
  input  logic [1:0]    a_rlanes,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_din,
  input  logic [1:0]    b_wlanes,
  input  logic          b_rd,
  input  logic [1:0]    b_rlanes,
  output logic [DW-1:0] a_dout,
  output logic [DW-1:0] b_dout
);

  localparam int LANES = 2;
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  // One bank per byte lane so each maps to its own true dual-port RAM.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];

    // Right first, left last: on a same-word double write the left data stays.
    always_ff @(posedge clk) begin
      if (b_wlanes[g]) bank[b_addr] <= b_din[g*LW +: LW];
      if (a_wlanes[g]) bank[a_addr] <= a_din[g*LW +: LW];
    end

    // Read-before-write: a same-cycle write is seen one cycle later.
    always_ff @(posedge clk) begin
      if (rst) begin
        a_dout[g*LW +: LW] <= '0;
        b_dout[g*LW +: LW] <= '0;
      end else begin
        a_dout[g*LW +: LW] <= (a_rd && a_rlanes[g]) ? bank[a_addr] : '0;
        b_dout[g*LW +: LW] <= (b_rd && b_rlanes[g]) ? bank[b_addr] : '0;
      end
    end
  end

  a_r2_left_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !a_rd |=> (a_dout == '0));

  a_r2_right_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !b_rd |=> (b_dout == '0));

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic          a_we,
  input  logic          b_we,
  input  logic          a_rd,
  input  logic          b_rd,
  output logic          a_irq,
  output logic          b_irq
);

  localparam int            DEPTH  = 1 << AW;
  localparam logic [AW-1:0] BOX_TO_RIGHT = AW'(DEPTH - 1);
  localparam logic [AW-1:0] BOX_TO_LEFT  = AW'(DEPTH - 2);

  logic post_r, take_r, post_l, take_l;

  assign post_r = a_we & (a_addr == BOX_TO_RIGHT);
  assign take_r = b_rd & (b_addr == BOX_TO_RIGHT);
  assign post_l = b_we & (b_addr == BOX_TO_LEFT);
  assign take_l = a_rd & (a_addr == BOX_TO_LEFT);

  // A new message outranks an acknowledgement in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_irq <= 1'b0;
      b_irq <= 1'b0;
    end else begin
      if (post_r)      b_irq <= 1'b1;
      else if (take_r) b_irq <= 1'b0;
      if (post_l)      a_irq <= 1'b1;
      else if (take_l) a_irq <= 1'b0;
    end
  end

  a_r8_right_raise: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_addr == BOX_TO_RIGHT) |=> b_irq);

  a_r8_right_clear: assert property (@(posedge clk) disable iff (rst)
    (b_rd && b_addr == BOX_TO_RIGHT && !(a_we && a_addr == BOX_TO_RIGHT)) |=> !b_irq);

  a_r9_left_raise: assert property (@(posedge clk) disable iff (rst)
    (b_we && b_addr == BOX_TO_LEFT) |=> a_irq);

  a_r9_left_clear: assert property (@(posedge clk) disable iff (rst)
    (a_rd && a_addr == BOX_TO_LEFT && !(b_we && b_addr == BOX_TO_LEFT)) |=> !a_irq);

  a_r10_right_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(b_irq) |-> $past(a_we && a_addr == BOX_TO_RIGHT));

  a_r10_left_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(a_irq) |-> $past(b_we && b_addr == BOX_TO_LEFT));

endmodule

// File: rtl/dpm_dual_ram.sv
module dpm_dual_ram
  import dpm_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic          a_oe,
  input  logic          a_hi,
  input  logic          a_lo,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  input  logic          a_busy_i,
  output logic [DW-1:0] a_dout,
  output logic          a_busy_o,
  output logic          a_irq,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic          b_oe,
  input  logic          b_hi,
  input  logic          b_lo,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_din,
  input  logic          b_busy_i,
  output logic [DW-1:0] b_dout,
  output logic          b_busy_o,
  output logic          b_irq
);

  port_op_t   op_a, op_b;
  logic       blk_a, blk_b;
  logic [1:0] wl_a, wl_b;

  assign op_a = decode_op(a_en, a_wr, a_oe, a_hi, a_lo);
  assign op_b = decode_op(b_en, b_wr, b_oe, b_hi, b_lo);

  dpm_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst(rst), .master(master),
    .a_en(a_en), .b_en(b_en), .a_addr(a_addr), .b_addr(b_addr),
    .a_busy_i(a_busy_i), .b_busy_i(b_busy_i),
    .a_block(blk_a), .b_block(blk_b),
    .a_busy_o(a_busy_o), .b_busy_o(b_busy_o)
  );

  assign wl_a = (op_a.wr && !blk_a) ? op_a.lanes : 2'b00;
  assign wl_b = (op_b.wr && !blk_b) ? op_b.lanes : 2'b00;

  dpm_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_din(a_din), .a_wlanes(wl_a), .a_rd(op_a.rd), .a_rlanes(op_a.lanes),
    .b_addr(b_addr), .b_din(b_din), .b_wlanes(wl_b), .b_rd(op_b.rd), .b_rlanes(op_b.lanes),
    .a_dout(a_dout), .b_dout(b_dout)
  );

  dpm_mailbox #(.AW(AW)) u_mbx (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .b_addr(b_addr),
    .a_we(|wl_a), .b_we(|wl_b),
    .a_rd(op_a.rd), .b_rd(op_b.rd),
    .a_irq(a_irq), .b_irq(b_irq)
  );

  a_r5_right_loses: assert property (@(posedge clk) disable iff (rst)
    (master && a_en && b_en && b_wr && a_addr == b_addr) |-> (wl_b == 2'b00));

endmodule

// File: tb/dpm_dual_ram_test.sv
module dpm_dual_ram_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master = 1'b1;
  logic        a_en = 0, a_wr = 0, a_oe = 0, a_hi = 0, a_lo = 0, a_busy_i = 0;
  logic        b_en = 0, b_wr = 0, b_oe = 0, b_hi = 0, b_lo = 0, b_busy_i = 0;
  logic [12:0] a_addr = '0, b_addr = '0;
  logic [15:0] a_din = '0, b_din = '0;
  logic [15:0] a_dout, b_dout;
  logic        a_busy_o, b_busy_o, a_irq, b_irq;

  always #2 clk = ~clk;

  dpm_dual_ram uut (
    .clk(clk), .rst(rst), .master(master),
    .a_en(a_en), .a_wr(a_wr), .a_oe(a_oe), .a_hi(a_hi), .a_lo(a_lo),
    .a_addr(a_addr), .a_din(a_din), .a_busy_i(a_busy_i),
    .a_dout(a_dout), .a_busy_o(a_busy_o), .a_irq(a_irq),
    .b_en(b_en), .b_wr(b_wr), .b_oe(b_oe), .b_hi(b_hi), .b_lo(b_lo),
    .b_addr(b_addr), .b_din(b_din), .b_busy_i(b_busy_i),
    .b_dout(b_dout), .b_busy_o(b_busy_o), .b_irq(b_irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // Reference model state
  logic [15:0] ref_mem [8192];
  logic [15:0] e_ad = '0, e_bd = '0;
  logic        e_abusy = 0, e_bbusy = 0, e_airq = 0, e_birq = 0;
  bit          live = 0;

  function automatic logic [15:0] keep(input logic [15:0] v, input logic hi, input logic lo);
    return {hi ? v[15:8] : 8'h00, lo ? v[7:0] : 8'h00};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_ad = '0; e_bd = '0; e_abusy = 0; e_bbusy = 0; e_airq = 0; e_birq = 0;
      live = 0;
    end else begin
      bit cont, ba, bb, ra, rb, wa, wb;
      live = 1;
      cont = a_en && b_en && (a_addr == b_addr);
      ba = master ? 1'b0 : a_busy_i;
      bb = master ? cont : b_busy_i;
      wa = a_en && a_wr && !ba && (a_hi || a_lo);
      wb = b_en && b_wr && !bb && (b_hi || b_lo);
      ra = a_en && a_oe && !a_wr;
      rb = b_en && b_oe && !b_wr;
      e_ad = ra ? keep(ref_mem[a_addr], a_hi, a_lo) : 16'h0;
      e_bd = rb ? keep(ref_mem[b_addr], b_hi, b_lo) : 16'h0;
      e_abusy = 0;
      e_bbusy = master && cont;
      if (wa && a_addr == 13'h1FFF) e_birq = 1;
      else if (rb && b_addr == 13'h1FFF) e_birq = 0;
      if (wb && b_addr == 13'h1FFE) e_airq = 1;
      else if (ra && a_addr == 13'h1FFE) e_airq = 0;
      if (wb) begin
        if (b_hi) ref_mem[b_addr][15:8] = b_din[15:8];
        if (b_lo) ref_mem[b_addr][7:0]  = b_din[7:0];
      end
      if (wa) begin
        if (a_hi) ref_mem[a_addr][15:8] = a_din[15:8];
        if (a_lo) ref_mem[a_addr][7:0]  = a_din[7:0];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk(cur_req, "a_dout", a_dout, e_ad);
      chk(cur_req, "b_dout", b_dout, e_bd);
      chk("R4", "a_busy_o", {15'h0, a_busy_o}, {15'h0, e_abusy});
      chk("R4", "b_busy_o", {15'h0, b_busy_o}, {15'h0, e_bbusy});
      chk("R9", "a_irq", {15'h0, a_irq}, {15'h0, e_airq});
      chk("R8", "b_irq", {15'h0, b_irq}, {15'h0, e_birq});
    end
  end

  task automatic pa(input logic en, input logic wr, input logic oe, input logic hi,
                    input logic lo, input logic [12:0] ad, input logic [15:0] d);
    a_en = en; a_wr = wr; a_oe = oe; a_hi = hi; a_lo = lo; a_addr = ad; a_din = d;
  endtask

  task automatic pb(input logic en, input logic wr, input logic oe, input logic hi,
                    input logic lo, input logic [12:0] ad, input logic [15:0] d);
    b_en = en; b_wr = wr; b_oe = oe; b_hi = hi; b_lo = lo; b_addr = ad; b_din = d;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    pa(0, 0, 0, 0, 0, 13'h0, 16'h0);
    pb(0, 0, 0, 0, 0, 13'h0, 16'h0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (4) tick();
    // R11: reset values
    chk("R11", "a_dout rst", a_dout, 16'h0);
    chk("R11", "b_dout rst", b_dout, 16'h0);
    chk("R11", "busy rst", {14'h0, a_busy_o, b_busy_o}, 16'h0);
    chk("R11", "irq rst", {14'h0, a_irq, b_irq}, 16'h0);
    rst = 0;

    // R1: fill from the left, read back from both sides
    cur_req = "R1";
    for (int i = 0; i < 8192; i++) begin
      pa(1, 1, 0, 1, 1, 13'(i), 16'(i * 16'h9E37) ^ 16'h5A5A);
      tick();
    end
    idle();
    for (int i = 0; i < 64; i++) begin
      pa(1, 0, 1, 1, 1, 13'(i * 37), 16'h0);
      pb(1, 0, 1, 1, 1, 13'(i * 53 + 1), 16'h0);
      tick();
    end
    pa(1, 1, 0, 1, 1, 13'h0123, 16'hBEEF);
    pb(1, 1, 0, 1, 1, 13'h0456, 16'hCAFE);
    tick();
    pa(1, 0, 1, 1, 1, 13'h0456, 16'h0);
    pb(1, 0, 1, 1, 1, 13'h0123, 16'h0);
    tick();

    // R2: output enable low, enable low, write cycle
    cur_req = "R2";
    pa(1, 0, 0, 1, 1, 13'h0123, 16'h0); pb(0, 1, 1, 1, 1, 13'h0123, 16'hFFFF); tick();
    pa(1, 1, 1, 1, 1, 13'h0200, 16'h1111); pb(0, 0, 1, 1, 1, 13'h0123, 16'h0); tick();
    pa(1, 0, 1, 1, 1, 13'h0123, 16'h0); pb(1, 0, 1, 1, 1, 13'h0200, 16'h0); tick();

    // R3: byte lanes
    cur_req = "R3";
    idle();
    pa(1, 1, 0, 1, 0, 13'h0300, 16'hA1B2); tick();
    pa(1, 1, 0, 0, 1, 13'h0301, 16'hC3D4); tick();
    pa(1, 1, 0, 0, 0, 13'h0302, 16'hFFFF); tick();
    for (int i = 0; i < 3; i++) begin
      pa(1, 0, 1, 1, 1, 13'(16'h0300 + i), 16'h0);
      pb(1, 0, 1, i == 0, i != 0, 13'(16'h0300 + i), 16'h0);
      tick();
    end

    // R4 / R5: contention in master mode
    cur_req = "R5";
    pa(1, 1, 0, 1, 1, 13'h0400, 16'h1234); pb(1, 1, 0, 1, 1, 13'h0400, 16'h9876); tick();
    pa(1, 0, 1, 1, 1, 13'h0400, 16'h0); pb(1, 0, 1, 1, 1, 13'h0401, 16'h0); tick();
    pa(1, 0, 1, 1, 1, 13'h0401, 16'h0); pb(1, 1, 0, 1, 1, 13'h0401, 16'h5555); tick();
    pa(0, 0, 0, 0, 0, 13'h0, 16'h0); pb(1, 0, 1, 1, 1, 13'h0401, 16'h0); tick();

    // R6: flow-through
    cur_req = "R6";
    pa(1, 1, 0, 1, 1, 13'h0500, 16'h7777); pb(1, 0, 1, 1, 1, 13'h0500, 16'h0); tick();
    pa(0, 0, 0, 0, 0, 13'h0, 16'h0); tick();
    pb(1, 1, 0, 1, 1, 13'h0600, 16'h6666); pa(1, 0, 1, 1, 1, 13'h0600, 16'h0); tick();
    pb(0, 0, 0, 0, 0, 13'h0, 16'h0); tick();

    // R7: slave mode
    cur_req = "R7";
    master = 0;
    idle();
    b_busy_i = 1;
    pb(1, 1, 0, 1, 1, 13'h0700, 16'hDEAD); tick();
    b_busy_i = 0; a_busy_i = 1;
    pa(1, 1, 0, 1, 1, 13'h0701, 16'hF00D); pb(1, 0, 1, 1, 1, 13'h0700, 16'h0); tick();
    a_busy_i = 0;
    pa(1, 1, 0, 1, 1, 13'h0702, 16'h1357); pb(1, 1, 0, 1, 1, 13'h0702, 16'h2468); tick();
    pa(1, 0, 1, 1, 1, 13'h0702, 16'h0); pb(1, 0, 1, 1, 1, 13'h0701, 16'h0); tick();
    master = 1;

    // R8 / R9 / R10: mailboxes
    cur_req = "R8";
    idle();
    pb(1, 0, 1, 1, 1, 13'h1FFF, 16'h0); tick();
    pa(1, 1, 0, 0, 1, 13'h1FFF, 16'h00AB); tick();
    pa(1, 0, 1, 1, 1, 13'h1FFF, 16'h0); tick();
    idle(); pb(1, 0, 1, 1, 1, 13'h1FFF, 16'h0); tick();
    cur_req = "R9";
    idle(); pb(1, 1, 0, 1, 0, 13'h1FFE, 16'hCD00); tick();
    pb(1, 0, 1, 1, 1, 13'h1FFE, 16'h0); tick();
    idle(); pa(1, 0, 1, 1, 1, 13'h1FFE, 16'h0); tick();
    cur_req = "R10";
    pb(1, 1, 0, 1, 1, 13'h1FFE, 16'h0102); pa(1, 0, 1, 1, 1, 13'h1FFE, 16'h0); tick();
    pa(1, 1, 0, 1, 1, 13'h1FFF, 16'h0304); pb(1, 0, 1, 1, 1, 13'h1FFF, 16'h0); tick();
    pa(1, 1, 0, 0, 0, 13'h1FFF, 16'h0); pb(1, 0, 1, 1, 1, 13'h1FFF, 16'h0); tick();
    idle(); pa(1, 0, 1, 1, 1, 13'h1FFE, 16'h0); tick();
    idle(); tick();

    // Mixed traffic over a few hot words, both modes
    cur_req = "R1";
    for (int i = 0; i < 4000; i++) begin
      logic [12:0] la, lb;
      la = ($urandom_range(0, 3) == 0) ? 13'(13'h1FFC + $urandom_range(0, 3)) : 13'($urandom_range(0, 3));
      lb = ($urandom_range(0, 3) == 0) ? 13'(13'h1FFC + $urandom_range(0, 3)) : 13'($urandom_range(0, 3));
      master   = ($urandom_range(0, 3) != 0);
      a_busy_i = ($urandom_range(0, 3) == 0);
      b_busy_i = ($urandom_range(0, 3) == 0);
      pa($urandom_range(0, 5) != 0, $urandom_range(0, 1), $urandom_range(0, 4) != 0,
         $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, la, 16'($urandom));
      pb($urandom_range(0, 5) != 0, $urandom_range(0, 1), $urandom_range(0, 4) != 0,
         $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, lb, 16'($urandom));
      tick();
    end
    idle();
    tick();
    tick();
    finish_run();
  end

endmodule